// File: doc/BRIEF.md
# Attention Acknowledge and Mute Controller

This block sits on the peripheral side of a three-line wired-OR serial bus that carries attention, clock and data lines. Whenever the host's attention line and a local acknowledge bit disagree, the block pulls the shared data line down. This gives the host an immediate hardware acknowledge that does not wait for the local CPU. Every change of attention, rising or falling, also latches an interrupt request for the local CPU. The request stays latched until the CPU clears it.

A gate select picks between two acknowledge variants. In the exclusive-OR variant the data line is pulled while attention and the acknowledge bit differ. In the AND variant the data line is pulled only while both are true. In mute mode the CPU-written acknowledge bit is ignored. The acknowledge bit then tracks attention on its own, so the device lets go of the data line almost at once and does not disturb a transfer between the host and another device. Mute also turns off the motor and activity LED outputs and hides the interrupt.

Top module: `aam_ctrl`

## Requirements
- R1: After reset, with attention and the acknowledge bit low, `data_pull` and `irq` are 0.
- R2: Exclusive-OR variant (`gate_sel_and`=0), not muted: `data_pull` = synchronized attention XOR `cpu_ack`. A change on `atn_in` reaches `data_pull` two rising clock edges after it is applied. A change on `cpu_ack` affects `data_pull` in the same cycle.
- R3: AND variant (`gate_sel_and`=1), not muted: `data_pull` = synchronized attention AND `cpu_ack`.
- R4: Each transition of attention, rising or falling, sets the interrupt flag. `irq` becomes 1 three rising edges after the change on `atn_in`, and not before.
- R5: The interrupt flag stays set until `irq_clr` is high at a rising edge. If `irq_clr` and an attention transition occur in the same cycle, the flag stays set.
- R6: Muted, exclusive-OR variant: the effective acknowledge follows synchronized attention one clock later. `data_pull` is 1 for exactly one clock per attention transition and is 0 at all other times.
- R7: Muted, AND variant: `data_pull` stays 0 whatever the values of attention and `cpu_ack`.
- R8: While muted, `cpu_ack` has no effect on `data_pull`.
- R9: While muted, `motor_on` and `led_on` are 0. While not muted, they equal `motor_req` and `led_req`.
- R10: While muted, `irq` is forced to 0, but the flag still records attention transitions. A transition recorded during mute appears on `irq` as soon as mute is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| atn_in | input | 1 | Host attention line, asynchronous, 1 = asserted |
| cpu_ack | input | 1 | CPU-written acknowledge bit |
| gate_sel_and | input | 1 | 0 = exclusive-OR acknowledge gate, 1 = AND gate |
| mute_en | input | 1 | Mute mode enable |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| motor_req | input | 1 | CPU request for the motor |
| led_req | input | 1 | CPU request for the activity LED |
| data_pull | output | 1 | Data line pull enable, 1 = line pulled to asserted |
| irq | output | 1 | Interrupt request to the local CPU |
| motor_on | output | 1 | Motor drive |
| led_on | output | 1 | Activity LED drive |

## Verification
The hardest case to reach is an `irq_clr` strobe that lands in the same cycle as a synchronized attention edge. That edge exists only between the second and third clock after `atn_in` changes. The bench applies the attention change on a falling edge, counts two rising edges, and then raises the clear strobe on the next falling edge so the two events coincide.

A second hard case is the one-clock data pulse in mute mode. The bench samples `data_pull` after each of the first three rising edges that follow an attention change, and it toggles `cpu_ack` while muted to show that the pulse does not depend on it.

// File: rtl/aam_pkg.sv
package aam_pkg;

  typedef enum logic {
    TRK_WAIT_ASSERT  = 1'b0,
    TRK_WAIT_RELEASE = 1'b1
  } trk_state_e;

  // Acknowledge gate: 1 means the data line is pulled.
  function automatic logic gate_out(input logic atn, input logic ack, input logic and_mode);
    if (and_mode) return atn & ack;
    return atn ^ ack;
  endfunction

endpackage

// File: rtl/aam_atn_sync.sv
module aam_atn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic atn_in,
  output logic atn_sync,
  output logic atn_edge
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          atn_prev;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], atn_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= atn_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) atn_prev <= 1'b0;
    else        atn_prev <= atn_sync;
  end

  assign atn_sync = chain[LAST];
  assign atn_edge = atn_sync ^ atn_prev;
endmodule

// File: rtl/aam_ack_track.sv
module aam_ack_track
  import aam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic atn_sync,
  input  logic cpu_ack,
  input  logic mute_en,
  input  logic gate_and,
  output logic ack_eff,
  output logic mute_ack
);
  trk_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TRK_WAIT_ASSERT;
      mute_ack <= 1'b0;
    end else if (!mute_en) begin
      // preload so entering mute never produces a stray pull
      mute_ack <= atn_sync;
      state    <= atn_sync ? TRK_WAIT_RELEASE : TRK_WAIT_ASSERT;
    end else begin
      unique case (state)
        TRK_WAIT_ASSERT: if (atn_sync) begin
          mute_ack <= 1'b1;
          state    <= TRK_WAIT_RELEASE;
        end
        TRK_WAIT_RELEASE: if (!atn_sync) begin
          mute_ack <= 1'b0;
          state    <= TRK_WAIT_ASSERT;
        end
        default: state <= TRK_WAIT_ASSERT;
      endcase
    end
  end

  always_comb begin
    if (!mute_en)      ack_eff = cpu_ack;
    else if (gate_and) ack_eff = 1'b0;
    else               ack_eff = mute_ack;
  end
endmodule

// File: rtl/aam_irq_flag.sv
module aam_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/aam_ctrl.sv
module aam_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic atn_in,
  input  logic cpu_ack,
  input  logic gate_sel_and,
  input  logic mute_en,
  input  logic irq_clr,
  input  logic motor_req,
  input  logic led_req,
  output logic data_pull,
  output logic irq,
  output logic motor_on,
  output logic led_on
);
  logic atn_sync;
  logic atn_edge;
  logic ack_eff;
  logic mute_ack;
  logic irq_flag;

  aam_atn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .atn_in   (atn_in),
    .atn_sync (atn_sync),
    .atn_edge (atn_edge)
  );

  aam_ack_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .atn_sync (atn_sync),
    .cpu_ack  (cpu_ack),
    .mute_en  (mute_en),
    .gate_and (gate_sel_and),
    .ack_eff  (ack_eff),
    .mute_ack (mute_ack)
  );

  aam_irq_flag u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (atn_edge),
    .clr     (irq_clr),
    .flag    (irq_flag)
  );

  assign data_pull = aam_pkg::gate_out(atn_sync, ack_eff, gate_sel_and);
  assign irq       = irq_flag  & ~mute_en;
  assign motor_on  = motor_req & ~mute_en;
  assign led_on    = led_req   & ~mute_en;
endmodule

// File: rtl/aam_ctrl_chk.sv
module aam_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mute_en,
  input logic gate_sel_and,
  input logic irq_clr,
  input logic data_pull,
  input logic irq,
  input logic motor_on,
  input logic led_on,
  input logic atn_edge,
  input logic irq_flag
);
  // R4
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    atn_edge |=> irq_flag);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R6
  mute_pulse_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && !gate_sel_and && data_pull) |-> atn_edge);

  // R7
  mute_and_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && gate_sel_and) |-> !data_pull);

  // R9
  mute_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_en |-> (!motor_on && !led_on));

  // R10
  mute_irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_en |-> !irq);
endmodule

bind aam_ctrl aam_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mute_en      (mute_en),
  .gate_sel_and (gate_sel_and),
  .irq_clr      (irq_clr),
  .data_pull    (data_pull),
  .irq          (irq),
  .motor_on     (motor_on),
  .led_on       (led_on),
  .atn_edge     (atn_edge),
  .irq_flag     (irq_flag)
);

// File: tb/sim_aam_ctrl.sv
`timescale 1ns/1ps
module sim_aam_ctrl;
  logic clk = 1'b0;
  logic rst_n, atn_in, cpu_ack, gate_sel_and, mute_en, irq_clr, motor_req, led_req;
  logic data_pull, irq, motor_on, led_on;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  aam_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .atn_in(atn_in), .cpu_ack(cpu_ack),
    .gate_sel_and(gate_sel_and), .mute_en(mute_en), .irq_clr(irq_clr),
    .motor_req(motor_req), .led_req(led_req),
    .data_pull(data_pull), .irq(irq), .motor_on(motor_on), .led_on(led_on)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // wait n rising edges, then sample 1 ns later
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 data_pull after reset", data_pull, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_xor();
    @(negedge clk) begin gate_sel_and = 0; cpu_ack = 0; atn_in = 1; end
    edges(1); chk("R2 xor not yet through sync", data_pull, 1'b0);
    edges(1); chk("R2 xor atn=1 ack=0", data_pull, 1'b1);
    @(negedge clk) cpu_ack = 1; #1;
    chk("R2 xor atn=1 ack=1", data_pull, 1'b0);
    @(negedge clk) atn_in = 0;
    edges(2); chk("R2 xor atn=0 ack=1", data_pull, 1'b1);
    @(negedge clk) cpu_ack = 0; #1;
    chk("R2 xor atn=0 ack=0", data_pull, 1'b0);
    clear_irq();
  endtask

  task automatic t_and();
    @(negedge clk) begin gate_sel_and = 1; cpu_ack = 1; end
    #1 chk("R3 and atn=0 ack=1", data_pull, 1'b0);
    @(negedge clk) atn_in = 1;
    edges(2); chk("R3 and atn=1 ack=1", data_pull, 1'b1);
    @(negedge clk) cpu_ack = 0; #1;
    chk("R3 and atn=1 ack=0", data_pull, 1'b0);
    @(negedge clk) atn_in = 0;
    edges(3);
    clear_irq();
    @(negedge clk) gate_sel_and = 0;
  endtask

  task automatic t_irq();
    @(negedge clk) atn_in = 1;
    edges(2); chk("R4 irq not early (rise)", irq, 1'b0);
    edges(1); chk("R4 irq on rising atn", irq, 1'b1);
    edges(3); chk("R5 irq sticky", irq, 1'b1);
    clear_irq(); #1;
    chk("R5 irq cleared", irq, 1'b0);
    @(negedge clk) atn_in = 0;
    edges(2); chk("R4 irq not early (fall)", irq, 1'b0);
    edges(1); chk("R4 irq on falling atn", irq, 1'b1);
    clear_irq();
  endtask

  task automatic t_irq_race();
    @(negedge clk) atn_in = 1;
    edges(2);                       // synchronized edge is now present
    @(negedge clk) irq_clr = 1'b1;  // clear coincides with the edge
    edges(1); chk("R5 set wins over clear", irq, 1'b1);
    @(negedge clk) irq_clr = 1'b0;
    edges(2); chk("R5 still set after race", irq, 1'b1);
    @(negedge clk) atn_in = 0;
    edges(3);
    clear_irq(); #1;
    chk("R5 cleared after race", irq, 1'b0);
  endtask

  task automatic t_mute_xor();
    @(negedge clk) begin gate_sel_and = 0; cpu_ack = 1; mute_en = 1; end
    edges(2); chk("R8 mute ignores cpu_ack (idle)", data_pull, 1'b0);
    @(negedge clk) atn_in = 1;
    edges(1); chk("R6 mute before sync", data_pull, 1'b0);
    edges(1); chk("R6 mute pulse on rise", data_pull, 1'b1);
    edges(1); chk("R6 mute released after one clock", data_pull, 1'b0);
    @(negedge clk) cpu_ack = 0; #1;
    chk("R8 mute ignores cpu_ack=0", data_pull, 1'b0);
    @(negedge clk) cpu_ack = 1; #1;
    chk("R8 mute ignores cpu_ack=1", data_pull, 1'b0);
    @(negedge clk) atn_in = 0;
    edges(2); chk("R6 mute pulse on fall", data_pull, 1'b1);
    edges(1); chk("R6 mute released after fall", data_pull, 1'b0);
    chk("R10 irq masked in mute", irq, 1'b0);
    @(negedge clk) mute_en = 0; #1;
    chk("R10 recorded edge shows after mute", irq, 1'b1);
    @(negedge clk) cpu_ack = 0;
    clear_irq();
  endtask

  task automatic t_mute_and();
    @(negedge clk) begin gate_sel_and = 1; cpu_ack = 1; mute_en = 1; end
    @(negedge clk) atn_in = 1;
    for (int i = 0; i < 4; i++) begin
      edges(1); chk("R7 mute and stays silent", data_pull, 1'b0);
    end
    @(negedge clk) atn_in = 0;
    edges(3);
    @(negedge clk) begin mute_en = 0; gate_sel_and = 0; cpu_ack = 0; end
    clear_irq();
  endtask

  task automatic t_motor();
    @(negedge clk) begin motor_req = 1; led_req = 1; end
    #1 chk("R9 motor follows req", motor_on, 1'b1);
    chk("R9 led follows req", led_on, 1'b1);
    @(negedge clk) mute_en = 1; #1;
    chk("R9 motor off in mute", motor_on, 1'b0);
    chk("R9 led off in mute", led_on, 1'b0);
    @(negedge clk) begin mute_en = 0; motor_req = 0; led_req = 0; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; atn_in = 0; cpu_ack = 0; gate_sel_and = 0; mute_en = 0;
    irq_clr = 0; motor_req = 0; led_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    t_reset();
    t_xor();
    t_and();
    t_irq();
    t_irq_race();
    t_mute_xor();
    t_mute_and();
    t_motor();
    done = 1;
    finish_run();
  end
endmodule